// File: doc/BRIEF.md
# Search Array Host Write Controller

This block is the host-facing write engine of a content-addressable search device. A host issues a write on an 11-bit command bus that is qualified by a valid strobe. The host also puts an address word on the 72-bit address/data bus. The command is presented as two half-phases, `cmdPhaseA` and `cmdPhaseB`, which are both sampled in the same clock cycle. The controller accepts the command only when the two half-phases agree and the device-ID field of the address word selects this device, either by an exact match or by the all-ones broadcast value. Once it accepts a command, the controller drives a write strobe together with a target select, an address, the write data and a 4-bit global-mask index towards the data array, the mask array or the register file.

A single write takes three cycles: a command cycle, a data cycle and an idle gap. A burst write takes its start address and its length from an internal burst register. That register is itself loaded by a register-space write. A burst of length n writes n consecutive addresses in n data cycles, so the whole operation lasts n + 2 cycles. While a write or its idle gap is in progress, the block raises `busy` and ignores any new command. A burst aimed at the register space writes nothing and raises a one-cycle error flag.

Top module: `hostWriteCtl`

## Requirements
- R1: A command is accepted only in a cycle where `cmdValid` is 1, the write opcode 2'b01 is on `cmdPhaseA[1:0]`, and `cmdPhaseA[9]` is 0. In any other case no write follows and `busy` stays 0.
- R2: A single write (`cmdPhaseA[2]`=0) asserts `wrEn` for exactly one cycle. That cycle is the cycle after the command cycle, and in it `wrData` equals `dq` of the same cycle. In the following cycle `busy` is 1 and `wrEn` is 0, and a command can be accepted again in the cycle after that.
- R3: A command is accepted only if `dq[25:21]` equals `devId` or equals 5'b11111 (broadcast).
- R4: `dq[20:19]` selects the target, and `wrTarget` carries it: 00 is the data array, 01 is the mask array, 11 is the register space. The value 10 causes the command to be ignored. For a single write, the register address is `dq[18:7]` zero-extended, and the array address is `dq[15:0]`.
- R5: `wrMaskIdx` during every data cycle equals {`cmdPhaseA[10]`, `cmdPhaseA[5:3]`} as captured in the command cycle.
- R6: If `cmdPhaseA` and `cmdPhaseB` differ in any bit other than bit 2, the command is ignored.
- R7: A burst (`cmdPhaseA[2]`=1) whose stored length is n>0 asserts `wrEn` in n consecutive cycles with addresses start, start+1, … start+n-1. It is followed by one idle cycle, for n+2 cycles in total. The array address on `dq` is ignored.
- R8: A single register-space write to register address 12'h010 loads the burst start address from `dq[15:0]` and the burst length from `dq[23:16]` of its data cycle. Both fields reset to 0.
- R9: A burst with stored length 0 performs no write. `busy` is 1 for one idle cycle after the command cycle.
- R10: A burst with target 11 performs no write and leaves `busy` at 0. Instead, `burstErr` is 1 for exactly the one cycle after the command cycle.
- R11: `busy` is 1 during every data cycle and during the idle gap, and 0 otherwise. A command presented while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Qualifies the command half-phases |
| cmdPhaseA | input | 11 | First command half-phase (opcode, mode, mask index, control bit) |
| cmdPhaseB | input | 11 | Second command half-phase, must match phase A except bit 2 |
| dq | input | 72 | Address word in the command cycle, write data in data cycles |
| devId | input | 5 | This device's identifier |
| wrEn | output | 1 | Write strobe, one per data cycle |
| wrTarget | output | 2 | Target select: 00 data, 01 mask, 11 register |
| wrAddr | output | 16 | Write address |
| wrData | output | 72 | Write data |
| wrMaskIdx | output | 4 | Global-mask index for the write |
| busy | output | 1 | Write or idle gap in progress |
| burstErr | output | 1 | One-cycle flag for a rejected register-space burst |

## Verification
The case most likely to hide a fault is a new, valid command that lands in the same cycle as the last burst beat or as the idle gap, when the sequencer is finishing one operation and the decoder already sees a legal next one. The bench provokes this by presenting fully valid commands during data beats and during the gap, and then presenting another command in the first cycle after the gap. A behavioural reference model judges on every clock that the overlapping commands produce no strobe and no change to the burst, and that the first command after the gap is taken at once.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  localparam int DATA_W      = 72;
  localparam int CMD_W       = 11;
  localparam int ID_W        = 5;
  localparam int ADDR_W      = 16;
  localparam int REG_ADDR_W  = 12;
  localparam int LEN_W       = 8;
  localparam int MASK_W      = 4;
  localparam int LOW_W       = 26;

  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] TGT_DATA   = 2'b00;
  localparam logic [1:0] TGT_MASK   = 2'b01;
  localparam logic [1:0] TGT_RSVD   = 2'b10;
  localparam logic [1:0] TGT_REG    = 2'b11;
  localparam logic [REG_ADDR_W-1:0] BURST_REG_ADDR = 12'h010;
  localparam logic [CMD_W-1:0] PHASE_CMP_MASK = 11'h7FB;

  typedef struct packed {
    logic ok;
    logic burst;
    logic regTgt;
    logic lenZero;
    logic lastBeat;
  } decInfo_t;

  typedef struct packed {
    logic accept;
    logic step;
  } ctlStrobes_t;
endpackage

// File: rtl/hwcDatapath.sv
module hwcDatapath
  import hwc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdValid,
  input  logic [CMD_W-1:0]       cmdPhaseA,
  input  logic [CMD_W-1:0]       cmdPhaseB,
  input  logic [LOW_W-1:0]       dqLow,
  input  logic [ID_W-1:0]        devId,
  input  ctlStrobes_t            strb,
  output decInfo_t               dec,
  output logic [1:0]             wrTarget,
  output logic [ADDR_W-1:0]      wrAddr,
  output logic [MASK_W-1:0]      wrMaskIdx
);
  logic [ID_W-1:0]   idField;
  logic [1:0]        tgtField;
  logic              idHit;
  logic              phaseSame;
  logic [ADDR_W-1:0] startAddr;

  logic [1:0]        tgtQ;
  logic [ADDR_W-1:0] addrQ;
  logic [MASK_W-1:0] maskQ;
  logic              burstModeQ;
  logic [LEN_W-1:0]  remQ;
  logic [ADDR_W-1:0] burstStartQ;
  logic [LEN_W-1:0]  burstLenQ;
  logic              burstRegWr;

  assign idField   = dqLow[25:21];
  assign tgtField  = dqLow[20:19];
  assign idHit     = (idField == devId) || (&idField);
  assign phaseSame = ((cmdPhaseA ^ cmdPhaseB) & PHASE_CMP_MASK) == '0;

  always_comb begin
    dec.ok       = cmdValid && (cmdPhaseA[1:0] == OP_WRITE) && !cmdPhaseA[9]
                   && phaseSame && idHit && (tgtField != TGT_RSVD);
    dec.burst    = cmdPhaseA[2];
    dec.regTgt   = (tgtField == TGT_REG);
    dec.lenZero  = (burstLenQ == '0);
    dec.lastBeat = !burstModeQ || (remQ == LEN_W'(1));
  end

  always_comb begin
    if (cmdPhaseA[2])             startAddr = burstStartQ;
    else if (tgtField == TGT_REG) startAddr = ADDR_W'(dqLow[18:7]);
    else                          startAddr = dqLow[ADDR_W-1:0];
  end

  assign burstRegWr = strb.step && !burstModeQ && (tgtQ == TGT_REG)
                      && (addrQ == ADDR_W'(BURST_REG_ADDR));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtQ        <= TGT_DATA;
      addrQ       <= '0;
      maskQ       <= '0;
      burstModeQ  <= 1'b0;
      remQ        <= '0;
      burstStartQ <= '0;
      burstLenQ   <= '0;
    end else begin
      if (strb.accept) begin
        tgtQ       <= tgtField;
        addrQ      <= startAddr;
        maskQ      <= {cmdPhaseA[10], cmdPhaseA[5:3]};
        burstModeQ <= cmdPhaseA[2];
        remQ       <= burstLenQ;
      end else if (strb.step) begin
        if (burstModeQ) addrQ <= addrQ + ADDR_W'(1);
        remQ <= remQ - LEN_W'(1);
      end
      if (burstRegWr) begin
        burstStartQ <= dqLow[ADDR_W-1:0];
        burstLenQ   <= dqLow[ADDR_W+LEN_W-1:ADDR_W];
      end
    end
  end

  assign wrTarget  = tgtQ;
  assign wrAddr    = addrQ;
  assign wrMaskIdx = maskQ;
endmodule

// File: rtl/hwcControl.sv
module hwcControl
  import hwc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  decInfo_t    dec,
  output ctlStrobes_t strb,
  output logic        busy,
  output logic        burstErr
);
  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_GAP} state_t;

  state_t stateQ, stateD;
  logic   errD, errQ;

  always_comb begin
    strb   = '0;
    stateD = stateQ;
    errD   = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (dec.ok) begin
          if (dec.burst && dec.regTgt) begin
            errD = 1'b1;
          end else begin
            strb.accept = 1'b1;
            stateD = (dec.burst && dec.lenZero) ? ST_GAP : ST_DATA;
          end
        end
      end
      ST_DATA: begin
        strb.step = 1'b1;
        if (dec.lastBeat) stateD = ST_GAP;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      errQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      errQ   <= errD;
    end
  end

  assign busy     = (stateQ != ST_IDLE);
  assign burstErr = errQ;
endmodule

// File: rtl/hostWriteCtl.sv
module hostWriteCtl
  import hwc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [CMD_W-1:0]  cmdPhaseA,
  input  logic [CMD_W-1:0]  cmdPhaseB,
  input  logic [DATA_W-1:0] dq,
  input  logic [ID_W-1:0]   devId,
  output logic              wrEn,
  output logic [1:0]        wrTarget,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [MASK_W-1:0] wrMaskIdx,
  output logic              busy,
  output logic              burstErr
);
  decInfo_t    dec;
  ctlStrobes_t strb;

  hwcDatapath u_dp (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid),
    .cmdPhaseA(cmdPhaseA), .cmdPhaseB(cmdPhaseB),
    .dqLow(dq[LOW_W-1:0]), .devId(devId), .strb(strb), .dec(dec),
    .wrTarget(wrTarget), .wrAddr(wrAddr), .wrMaskIdx(wrMaskIdx)
  );

  hwcControl u_ctl (
    .clk(clk), .rstN(rstN), .dec(dec), .strb(strb),
    .busy(busy), .burstErr(burstErr)
  );

  assign wrEn   = strb.step;
  assign wrData = dq;
endmodule

// File: rtl/hostWriteCtlChecker.sv
module hostWriteCtlChecker (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [15:0] wrAddr,
  input logic [3:0]  wrMaskIdx,
  input logic        busy,
  input logic        burstErr
);
  AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> busy); // R11
  AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    burstErr |-> (!busy && !wrEn)); // R10
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    burstErr |=> !burstErr); // R10
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && $past(wrEn)) |-> $stable(wrMaskIdx)); // R5
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && $past(wrEn)) |-> (wrAddr == $past(wrAddr) + 16'd1)); // R7
  AST_GAP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrEn) |-> busy); // R2
  AST_GAP_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrEn) |=> !busy); // R2
endmodule

bind hostWriteCtl hostWriteCtlChecker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrMaskIdx(wrMaskIdx), .busy(busy), .burstErr(burstErr)
);

// File: tb/hostWriteCtl_bench.sv
module hostWriteCtl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [10:0] cmdPhaseA = '0;
  logic [10:0] cmdPhaseB = '0;
  logic [71:0] dq = '0;
  logic [4:0]  devId = 5'd6;
  logic        wrEn, busy, burstErr;
  logic [1:0]  wrTarget;
  logic [15:0] wrAddr;
  logic [71:0] wrData;
  logic [3:0]  wrMaskIdx;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  string curTag = "R1";

  always #5 clk = ~clk;

  hostWriteCtl u_hostWriteCtl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdPhaseA(cmdPhaseA),
    .cmdPhaseB(cmdPhaseB), .dq(dq), .devId(devId), .wrEn(wrEn),
    .wrTarget(wrTarget), .wrAddr(wrAddr), .wrData(wrData),
    .wrMaskIdx(wrMaskIdx), .busy(busy), .burstErr(burstErr)
  );

  // Behavioural reference: phase 0 idle, 1 writing, 2 gap
  int mPhase = 0, mRem = 0, mAddr = 0, mTgt = 0, mMask = 0;
  int mBurst = 0, mStart = 0, mLen = 0, mErr = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mPhase = 0; mRem = 0; mAddr = 0; mTgt = 0; mMask = 0;
      mBurst = 0; mStart = 0; mLen = 0; mErr = 0;
    end else begin
      int id, tgt;
      bit ok;
      id  = int'(dq[25:21]);
      tgt = int'(dq[20:19]);
      ok  = cmdValid && cmdPhaseA[1:0] == 2'b01 && !cmdPhaseA[9]
            && ((cmdPhaseA | 11'h004) == (cmdPhaseB | 11'h004))
            && (id == int'(devId) || id == 31) && tgt != 2;
      mErr = 0;
      if (mPhase == 0) begin
        if (ok) begin
          if (cmdPhaseA[2] && tgt == 3) mErr = 1;
          else begin
            mBurst = cmdPhaseA[2];
            mTgt   = tgt;
            mMask  = cmdPhaseA[10] * 8 + int'(cmdPhaseA[5:3]);
            mRem   = mLen;
            if (mBurst) mAddr = mStart;
            else if (tgt == 3) mAddr = int'(dq[18:7]);
            else mAddr = int'(dq[15:0]);
            mPhase = (mBurst && mLen == 0) ? 2 : 1;
          end
        end
      end else if (mPhase == 1) begin
        if (!mBurst && mTgt == 3 && mAddr == 16) begin
          mStart = int'(dq[15:0]);
          mLen   = int'(dq[23:16]);
        end
        if (!mBurst || mRem == 1) mPhase = 2;
        if (mBurst) mAddr = (mAddr + 1) % 65536;
        mRem = mRem - 1;
      end else mPhase = 0;
    end
  end

  task automatic chk(string field, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d",
               curTag, field, act, exp, cycles);
    end
  endtask

  task automatic compareAll();
    chk("wrEn", wrEn, mPhase == 1);
    chk("busy", busy, mPhase != 0);
    chk("burstErr", burstErr, mErr);
    if (mPhase == 1) begin
      chk("wrTarget", wrTarget, mTgt);
      chk("wrAddr", wrAddr, mAddr);
      chk("wrMaskIdx", wrMaskIdx, mMask);
      chk("wrData", wrData, dq);
    end
  endtask

  task automatic drive(bit v, logic [10:0] a, logic [10:0] b, logic [71:0] d);
    @(negedge clk);
    cmdValid = v; cmdPhaseA = a; cmdPhaseB = b; dq = d;
    #1 compareAll();
  endtask

  function automatic logic [10:0] mk(bit burst, logic [3:0] mask, bit b9, logic [1:0] op);
    logic [10:0] c;
    c = '0;
    c[1:0] = op; c[2] = burst; c[5:3] = mask[2:0]; c[10] = mask[3]; c[9] = b9;
    return c;
  endfunction

  function automatic logic [71:0] aw(logic [4:0] id, logic [1:0] tgt, logic [18:0] low);
    return {46'h0, id, tgt, low};
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, '0, '0, 72'h0);
  endtask

  task automatic cmdOnly(bit burst, logic [3:0] mask, logic [4:0] id, logic [1:0] tgt, logic [18:0] low);
    drive(1, mk(burst, mask, 0, 2'b01), mk(burst, mask, 0, 2'b01), aw(id, tgt, low));
  endtask

  task automatic single(logic [3:0] mask, logic [4:0] id, logic [1:0] tgt,
                        logic [18:0] low, logic [71:0] data);
    cmdOnly(0, mask, id, tgt, low);
    drive(0, '0, '0, data);
    idle(1);
  endtask

  initial begin
    // reset state
    curTag = "R11";
    idle(3);
    @(negedge clk) rstN = 1'b1;
    idle(2);

    // R8: program burst register start 0x1230, length 3
    curTag = "R8";
    single(4'h2, 5'd6, 2'b11, 19'(12'h010) << 7, {48'h0, 8'd3, 16'h1230});
    idle(1);

    // R2 and R5: single data-array write with mask 9
    curTag = "R2";
    single(4'h9, 5'd6, 2'b00, 19'h000AB, 72'hA5_0123_4567_89AB_CDEF);
    curTag = "R5";
    single(4'hE, 5'd6, 2'b00, 19'h0FFFF, 72'hFF_FFFF_FFFF_FFFF_FFFF);

    // R3: broadcast to mask array, then a foreign ID
    curTag = "R3";
    single(4'h1, 5'd31, 2'b01, 19'h01234, 72'h11_2222_3333_4444_5555);
    single(4'h1, 5'd7, 2'b00, 19'h00055, 72'h99);

    // R4: register address decode, reserved target ignored
    curTag = "R4";
    single(4'h0, 5'd6, 2'b11, 19'h7FF80, 72'h42);
    single(4'h0, 5'd6, 2'b10, 19'h00001, 72'h43);

    // R1: bit9 set, wrong opcode, valid low
    curTag = "R1";
    drive(1, mk(0, 4'h3, 1, 2'b01), mk(0, 4'h3, 1, 2'b01), aw(6, 0, 19'h10));
    drive(1, mk(0, 4'h3, 0, 2'b10), mk(0, 4'h3, 0, 2'b10), aw(6, 0, 19'h10));
    drive(0, mk(0, 4'h3, 0, 2'b01), mk(0, 4'h3, 0, 2'b01), aw(6, 0, 19'h10));
    idle(2);

    // R6: phase mismatch in mask bit, then mismatch only in bit 2 (accepted)
    curTag = "R6";
    drive(1, mk(0, 4'h3, 0, 2'b01), mk(0, 4'h7, 0, 2'b01), aw(6, 0, 19'h20));
    idle(2);
    drive(1, mk(0, 4'h3, 0, 2'b01), mk(1, 4'h3, 0, 2'b01), aw(6, 0, 19'h21));
    drive(0, '0, '0, 72'h77);
    idle(1);

    // R7 and R11: burst of 3 with colliding commands during beats and gap
    curTag = "R7";
    cmdOnly(1, 4'hA, 5'd6, 2'b00, 19'h0FFFF);
    curTag = "R11";
    drive(1, mk(0, 4'h5, 0, 2'b01), mk(0, 4'h5, 0, 2'b01), aw(6, 3, 19'(12'h010) << 7));
    drive(1, mk(1, 4'h5, 0, 2'b01), mk(1, 4'h5, 0, 2'b01), aw(31, 1, 19'h5));
    drive(1, mk(0, 4'h5, 0, 2'b01), mk(0, 4'h5, 0, 2'b01), aw(6, 0, 19'h6));
    drive(1, mk(0, 4'h5, 0, 2'b01), mk(0, 4'h5, 0, 2'b01), aw(6, 0, 19'h7));
    // command right after the gap is taken
    curTag = "R2";
    drive(1, mk(0, 4'h4, 0, 2'b01), mk(0, 4'h4, 0, 2'b01), aw(6, 1, 19'h00321));
    drive(0, '0, '0, 72'hBEEF);
    idle(1);

    // R7: burst to mask array
    curTag = "R7";
    cmdOnly(1, 4'h6, 5'd31, 2'b01, 19'h0);
    for (int i = 0; i < 3; i++) drive(0, '0, '0, 72'(i + 100));
    idle(2);

    // R10: burst aimed at register space
    curTag = "R10";
    cmdOnly(1, 4'h2, 5'd6, 2'b11, 19'(12'h010) << 7);
    idle(2);

    // R8 then R9: length 0 burst
    curTag = "R8";
    single(4'h0, 5'd6, 2'b11, 19'(12'h010) << 7, {48'h0, 8'd0, 16'hFFFE});
    curTag = "R9";
    cmdOnly(1, 4'h8, 5'd6, 2'b00, 19'h0);
    idle(3);

    // R7: length 2 burst wrapping the address
    curTag = "R8";
    single(4'h0, 5'd6, 2'b11, 19'(12'h010) << 7, {48'h0, 8'd2, 16'hFFFF});
    curTag = "R7";
    cmdOnly(1, 4'hF, 5'd6, 2'b00, 19'h0);
    drive(0, '0, '0, 72'h1);
    drive(0, '0, '0, 72'h2);
    idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    miscompares++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule